// File: doc/BRIEF.md
# Piecewise Table Square Root

This unit returns an approximate fixed-point square root of an unsigned 18-bit integer. The input is at most 195075, which is the largest squared distance between two 8-bit RGB pixels. The unit serves the distance stage of a colour vector filter, where an exact iterative root would cost too many cycles or too much area. A single 1024-entry table holds `floor(sqrt(k) * 2^9)` for `k = 0..1023`, so each entry carries 9 fractional bits.

Inputs larger than the table are brought into range by a right shift of the input by an even amount `2s`. The table result is then shifted left by `s`. The segment index `s` (0 to 4) comes from the position of the highest set bit of the input. No multiplier or divider is used.

Data enters and leaves through valid/ready handshakes. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid`/`out_data` after that edge. The result stays on the port, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure from `out_ready` therefore stalls the input one-for-one, and no word is lost or repeated.

Top module: `sqrt_piecewise`

## Requirements
- R1: After synchronous reset (`rst_n` low at a rising edge), `out_valid` is 0 and `in_ready` is 1.
- R2: For an input x in 0..1023 (segment 0), `out_data` equals floor(sqrt(x)·512). The input goes to the table unshifted.
- R3: For x in 1024..4095 (segment 1), `out_data` equals T[x>>2]·2, where T[k] = floor(sqrt(k)·512).
- R4: For x in 4096..16383 (segment 2), `out_data` equals T[x>>4]·4.
- R5: For x in 16384..65535 (segment 3), `out_data` equals T[x>>6]·8.
- R6: For x in 65536..195075 (segment 4), `out_data` equals T[x>>8]·16, so its four low bits are zero.
- R7: An input above 195075 produces the same result as 195075, and no result reaches 442·512.
- R8: An input of zero produces an output of zero.
- R9: A word accepted at a rising edge gives `out_valid` = 1 with its result right after that edge. Without a new accept, `out_valid` falls after an edge where `out_ready` was high.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold and `in_ready` is 0. A word offered during the stall is accepted only after the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_data | input | 18 | Unsigned squared distance |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 18 | Root, unsigned, 9 fractional bits |

## Verification
A wrong table entry or segment decision appears as a wrong `out_data` in the cycle right after the offending word is accepted. The bench compares every result against its own model, including the segment boundaries 1023/1024, 4095/4096, 16383/16384 and 65535/65536. The model finds each root by binary search on squares. A wrong handshake state shows either as a lost or changed result during a stall, or as `in_ready` staying high while the output is blocked. The bench checks both on the first negative edge of the stall.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
  parameter int BASE_W = 10;   // table address width
  parameter int FRAC_W = 9;    // fractional bits in each entry
  parameter int NSEG   = 5;    // number of range segments
  parameter int MAX_IN = 195075;

  // floor(sqrt(k * 2^(2*frac))) by restoring bit method, used at elaboration
  function automatic int unsigned fx_root(int unsigned k, int frac);
    int unsigned v;
    int unsigned r;
    v = k << (2 * frac);
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      int unsigned t;
      t = r | (32'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction
endpackage

// File: rtl/sqrt_range_reduce.sv
module sqrt_range_reduce
  import sqrt_pkg::*;
#(
  parameter int B_W   = BASE_W,
  parameter int N_SEG = NSEG,
  parameter int LIMIT = MAX_IN,
  localparam int I_W   = B_W + 2 * (N_SEG - 1),
  localparam int S_W   = $clog2(N_SEG)
) (
  input  logic [I_W-1:0] x,
  output logic [B_W-1:0] idx,
  output logic [S_W-1:0] seg
);
  logic [I_W-1:0]   xc;
  logic [N_SEG-2:0] above;

  assign xc = (x > I_W'(LIMIT)) ? I_W'(LIMIT) : x;

  // thermometer of "input reaches segment s" from the leading bit position
  for (genvar s = 1; s < N_SEG; s++) begin : g_seg
    assign above[s-1] = |xc[I_W-1 : B_W + 2*(s-1)];
  end

  always_comb begin
    seg = '0;
    for (int s = 0; s < N_SEG - 1; s++) begin
      if (above[s]) seg = S_W'(s + 1);
    end
  end

  logic [I_W-1:0] shifted;
  assign shifted = xc >> (2 * seg);
  assign idx     = shifted[B_W-1:0];
endmodule

// File: rtl/sqrt_rom.sv
module sqrt_rom
  import sqrt_pkg::*;
#(
  parameter int B_W = BASE_W,
  parameter int F_W = FRAC_W,
  localparam int DEPTH = 1 << B_W,
  localparam int E_W   = B_W / 2 + F_W
) (
  input  logic [B_W-1:0] addr,
  output logic [E_W-1:0] data
);
  logic [E_W-1:0] entries [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign entries[k] = E_W'(fx_root(k, F_W));
  end

  assign data = entries[addr];
endmodule

// File: rtl/sqrt_piecewise.sv
module sqrt_piecewise
  import sqrt_pkg::*;
#(
  parameter int B_W   = BASE_W,
  parameter int F_W   = FRAC_W,
  parameter int N_SEG = NSEG,
  parameter int LIMIT = MAX_IN,
  localparam int I_W  = B_W + 2 * (N_SEG - 1),
  localparam int E_W  = B_W / 2 + F_W,
  localparam int O_W  = E_W + N_SEG - 1,
  localparam int S_W  = $clog2(N_SEG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [I_W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [O_W-1:0] out_data
);
  logic [B_W-1:0] idx;
  logic [S_W-1:0] seg;
  logic [E_W-1:0] entry;
  logic [O_W-1:0] scaled;
  logic           take;

  sqrt_range_reduce #(.B_W(B_W), .N_SEG(N_SEG), .LIMIT(LIMIT)) u_reduce (
    .x  (in_data),
    .idx(idx),
    .seg(seg)
  );

  sqrt_rom #(.B_W(B_W), .F_W(F_W)) u_rom (
    .addr(idx),
    .data(entry)
  );

  assign scaled   = O_W'(entry) << seg;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= scaled;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sqrt_piecewise_chk.sv
module sqrt_piecewise_chk #(
  parameter int I_W = 18,
  parameter int O_W = 18,
  parameter int CAP = 442 * 512
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [I_W-1:0] in_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic [O_W-1:0] out_data
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data == '0 |=> out_data == '0);

  p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data < O_W'(CAP));

  p_lowbits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data >= I_W'(65536) |=> out_data[3:0] == 4'd0);
endmodule

bind sqrt_piecewise sqrt_piecewise_chk #(.I_W(I_W), .O_W(O_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sqrt_piecewise_tb.sv
`timescale 1ns/1ps
module sqrt_piecewise_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sqrt_piecewise u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // table value by binary search on squares
  function automatic int unsigned t_ref(int unsigned k);
    longint unsigned v, lo, hi, mid;
    v = longint'(k) << 18;
    lo = 0; hi = 32767;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return int'(lo);
  endfunction

  function automatic int unsigned model(int unsigned x);
    int unsigned c;
    c = (x > 195075) ? 195075 : x;
    if (c < 1024)       return t_ref(c);
    else if (c < 4096)  return t_ref(c >> 2) << 1;
    else if (c < 16384) return t_ref(c >> 4) << 2;
    else if (c < 65536) return t_ref(c >> 6) << 3;
    else                return t_ref(c >> 8) << 4;
  endfunction

  function automatic string tag(int unsigned x);
    if (x > 195075)     return "R7";
    if (x == 0)         return "R8";
    if (x < 1024)       return "R2";
    if (x < 4096)       return "R3";
    if (x < 16384)      return "R4";
    if (x < 65536)      return "R5";
    return "R6";
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one word through with no stall, checked on the next negative edge (R9)
  task automatic apply(int unsigned x);
    @(negedge clk);
    in_valid = 1'b1; in_data = 18'(x); out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 valid", out_valid, 1);
    check(tag(x), out_data, model(x));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;

    // directed corners
    apply(0);            // R8
    apply(1); apply(2); apply(1023);               // R2
    apply(1024); apply(4095);                      // R3
    apply(4096); apply(16383);                     // R4
    apply(16384); apply(65535);                    // R5
    apply(65536); apply(195075);                   // R6
    apply(195076); apply(262143);                  // R7
    check("R7 clamp", model(262143), model(195075));

    // drain after idle (R9)
    @(negedge clk);
    check("R9 drain", out_valid, 0);

    // back-pressure (R10)
    @(negedge clk);
    in_valid = 1'b1; in_data = 18'd5000; out_ready = 1'b0;
    @(negedge clk);
    in_data = 18'd70000;
    check("R10 first", out_data, model(5000));
    check("R10 in_ready", in_ready, 0);
    @(negedge clk);
    check("R10 hold", out_data, model(5000));
    check("R10 hold valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next", out_data, model(70000));
    @(negedge clk);
    check("R10 no repeat", out_valid, 0);

    // constrained random per segment
    for (int i = 0; i < 400; i++) begin
      int unsigned x;
      case ($urandom % 6)
        0: x = $urandom % 1024;
        1: x = 1024 + $urandom % 3072;
        2: x = 4096 + $urandom % 12288;
        3: x = 16384 + $urandom % 49152;
        4: x = 65536 + $urandom % 129540;
        default: x = 195076 + $urandom % 67068;
      endcase
      apply(x);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule